// File: doc/BRIEF.md
# Static LCD Digit Recovery

This block watches the logic-level lines of one static seven-segment LCD digit: the backplane and the seven segment lines. It works out which segments are lit and turns a stable segment pattern into a BCD digit. A segment is lit when its line is driven opposite to the backplane. The raw XOR of the two lines glitches while the edges are skewed, so the block samples the XOR only once a programmable delay has passed after each backplane transition. A pattern counts only once it has repeated over several sample points in a row.

An accepted pattern is decoded by exact match against the ten numeric glyphs. The block also accepts the tail-less forms of 6 and 9. An all-dark digit raises a blank flag. Every other pattern, such as a letter glyph, raises an invalid flag and leaves the last good digit on the output. A one-cycle strobe marks each change of the accepted pattern. This lets a monitor pick up readings from an instrument whose display is driven by a controller the user cannot reach.

Top module: `lcd_digit_recover`

## Requirements
- R1: The lit state of each segment is the segment line XOR the backplane line. Lit patterns are therefore recovered in both backplane phases.
- R2: Both backplane edges start a settle count. The segments are sampled `settle_i`+1 cycles after the synchronized edge is seen. If another edge arrives before that sample is taken, the sample is dropped, so a settle delay longer than a backplane half-period produces no updates.
- R3: A pattern is accepted only after it has been seen on STABLE_N consecutive samples (default 3). A pattern that lasts for fewer samples has no effect on the outputs.
- R4: Pattern bits are ordered with segment A in bit 6 down to segment G in bit 0. The digits are matched exactly: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011. A match drives `bcd_o` to the digit and clears both flags.
- R5: Pattern 0011111 decodes as 6 and pattern 1110011 decodes as 9.
- R6: An accepted all-dark pattern 0000000 sets `blank_o`, clears `invalid_o` and holds `bcd_o`. The two flags are never both set.
- R7: Any other accepted pattern sets `invalid_o`, clears `blank_o` and holds the last valid `bcd_o`.
- R8: `update_o` pulses for exactly one cycle, and only when the newly accepted pattern differs from the previously accepted one. `bcd_o` never changes without it.
- R9: While reset is held, `bcd_o`=0, `blank_o`=1, `invalid_o`=0, `update_o`=0, and the stability count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the backplane |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bp_i | input | 1 | Backplane line, logic level |
| seg_i | input | 7 | Segment lines, A in bit 6 to G in bit 0 |
| settle_i | input | CNT_W | Settle delay after each backplane edge, in cycles |
| bcd_o | output | 4 | Last valid decoded digit |
| blank_o | output | 1 | Accepted pattern is all dark |
| invalid_o | output | 1 | Accepted pattern is not a digit |
| update_o | output | 1 | One-cycle strobe on each change of accepted pattern |

## Verification
The assertions assume that `bp_i` and `seg_i` are plain levels that change at most once per clock. They also assume that `settle_i` stays fixed except between stimulus phases. The bench drives a backplane with a 16-cycle half-period. The segment lines follow each backplane edge with a random skew of up to four cycles, while the settle delay is six cycles, so the glitch window always ends before the sample point. The one exception is a deliberate phase in which the settle delay is longer than the half-period. That phase checks that the samples are dropped.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_pat_t;

  typedef struct packed {
    logic       hit;
    logic [3:0] digit;
  } dec_t;

  // bit6 = A ... bit0 = G
  function automatic dec_t match_digit(seg_pat_t p);
    dec_t d;
    d.hit = 1'b1;
    unique case (p)
      7'b1111110: d.digit = 4'd0;
      7'b0110000: d.digit = 4'd1;
      7'b1101101: d.digit = 4'd2;
      7'b1111001: d.digit = 4'd3;
      7'b0110011: d.digit = 4'd4;
      7'b1011011: d.digit = 4'd5;
      7'b1011111,
      7'b0011111: d.digit = 4'd6;
      7'b1110000: d.digit = 4'd7;
      7'b1111111: d.digit = 4'd8;
      7'b1111011,
      7'b1110011: d.digit = 4'd9;
      default: begin
        d.hit   = 1'b0;
        d.digit = 4'd0;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lcdr_sync.sv
module lcdr_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lcdr_sampler.sv
module lcdr_sampler
  import lcdr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bp_i,
  input  seg_pat_t         seg_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             smp_v_o,
  output seg_pat_t         smp_pat_o
);
  logic             bp_q, armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bp_edge;

  assign bp_edge = bp_i ^ bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q      <= 1'b0;
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      smp_v_o   <= 1'b0;
      smp_pat_o <= '0;
    end else begin
      bp_q    <= bp_i;
      smp_v_o <= 1'b0;
      if (bp_edge) begin
        // a pending sample is dropped here
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == settle_i) begin
          smp_v_o   <= 1'b1;
          smp_pat_o <= seg_i ^ {SEG_W{bp_i}};
          armed_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcdr_filter.sv
module lcdr_filter
  import lcdr_pkg::*;
#(
  parameter int STABLE_N = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     smp_v_i,
  input  seg_pat_t smp_pat_i,
  output logic     acc_v_o,
  output seg_pat_t acc_pat_o
);
  localparam int RW = $clog2(STABLE_N + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STABLE_N);

  seg_pat_t      cand_q;
  logic [RW-1:0] run_q, run_nxt;
  logic          same, saturated;

  assign same      = (smp_pat_i == cand_q);
  assign saturated = same && (run_q == RUN_MAX);

  always_comb begin
    if (!same)         run_nxt = RW'(1);
    else if (saturated) run_nxt = RUN_MAX;
    else               run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q    <= '0;
      run_q     <= '0;
      acc_v_o   <= 1'b0;
      acc_pat_o <= '0;
    end else begin
      acc_v_o <= 1'b0;
      if (smp_v_i) begin
        cand_q <= smp_pat_i;
        run_q  <= run_nxt;
        if (run_nxt == RUN_MAX && !saturated) begin
          acc_v_o   <= 1'b1;
          acc_pat_o <= smp_pat_i;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_digit_recover.sv
module lcd_digit_recover
  import lcdr_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STABLE_N = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bp_i,
  input  logic [6:0]       seg_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic [3:0]       bcd_o,
  output logic             blank_o,
  output logic             invalid_o,
  output logic             update_o
);
  localparam int SYNC_W = SEG_W + 1;

  logic [SYNC_W-1:0] raw, synced;
  logic              smp_v, acc_v;
  seg_pat_t          smp_pat, acc_pat, acc_q;
  dec_t              dec;

  assign raw = {bp_i, seg_i};

  lcdr_sync #(.W(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  lcdr_sampler #(.CNT_W(CNT_W)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bp_i     (synced[SYNC_W-1]),
    .seg_i    (synced[SEG_W-1:0]),
    .settle_i (settle_i),
    .smp_v_o  (smp_v),
    .smp_pat_o(smp_pat)
  );

  lcdr_filter #(.STABLE_N(STABLE_N)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_v_i  (smp_v),
    .smp_pat_i(smp_pat),
    .acc_v_o  (acc_v),
    .acc_pat_o(acc_pat)
  );

  assign dec = match_digit(acc_pat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      bcd_o     <= 4'd0;
      blank_o   <= 1'b1;
      invalid_o <= 1'b0;
      update_o  <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (acc_v && acc_pat != acc_q) begin
        acc_q    <= acc_pat;
        update_o <= 1'b1;
        if (dec.hit) begin
          bcd_o     <= dec.digit;
          blank_o   <= 1'b0;
          invalid_o <= 1'b0;
        end else if (acc_pat == '0) begin
          blank_o   <= 1'b1;
          invalid_o <= 1'b0;
        end else begin
          blank_o   <= 1'b0;
          invalid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcdr_checker.sv
module lcdr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] bcd_o,
  input logic       blank_o,
  input logic       invalid_o,
  input logic       update_o
);
  assert_update_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  assert_bcd_needs_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bcd_o) |-> update_o);

  assert_flags_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(blank_o && invalid_o));

  assert_blank_holds_bcd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blank_o) |-> $stable(bcd_o));

  assert_invalid_holds_bcd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalid_o) |-> $stable(bcd_o));

  assert_bcd_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_o <= 4'd9);
endmodule

bind lcd_digit_recover lcdr_checker u_lcdr_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bcd_o    (bcd_o),
  .blank_o  (blank_o),
  .invalid_o(invalid_o),
  .update_o (update_o)
);

// File: tb/tb_lcd_digit_recover.sv
module tb_lcd_digit_recover;
  localparam int CNT_W = 8;
  localparam int HALF  = 16;
  localparam int SETTLE = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bp = 1'b0;
  logic [6:0]       seg = '0;
  logic [CNT_W-1:0] settle = CNT_W'(SETTLE);
  logic [3:0]       bcd_o;
  logic             blank_o, invalid_o, update_o;

  int total = 0, bad = 0, upd_cnt = 0;
  bit done = 0;

  // model of accepted state
  logic [6:0] m_pat = '0;
  logic [3:0] m_bcd = 4'd0;
  logic       m_blank = 1'b1, m_inv = 1'b0;

  always #2 clk = ~clk;

  lcd_digit_recover #(.CNT_W(CNT_W), .STABLE_N(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bp_i(bp), .seg_i(seg), .settle_i(settle),
    .bcd_o(bcd_o), .blank_o(blank_o), .invalid_o(invalid_o), .update_o(update_o)
  );

  always @(negedge clk) if (rst_ni && update_o) upd_cnt++;

  // returns digit 0..9, 10 = blank, 11 = not a digit
  function automatic int ref_decode(logic [6:0] p);
    case (p)
      7'b1111110: return 0;
      7'b0110000: return 1;
      7'b1101101: return 2;
      7'b1111001: return 3;
      7'b0110011: return 4;
      7'b1011011: return 5;
      7'b1011111, 7'b0011111: return 6;
      7'b1110000: return 7;
      7'b1111111: return 8;
      7'b1111011, 7'b1110011: return 9;
      7'b0000000: return 10;
      default:    return 11;
    endcase
  endfunction

  function automatic logic [6:0] glyph(int d);
    case (d)
      0: return 7'b1111110; 1: return 7'b0110000; 2: return 7'b1101101;
      3: return 7'b1111001; 4: return 7'b0110011; 5: return 7'b1011011;
      6: return 7'b1011111; 7: return 7'b1110000; 8: return 7'b1111111;
      9: return 7'b1111011; 10: return 7'b0011111; default: return 7'b1110011;
    endcase
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // drive the lit pattern for n backplane half-periods, segment edges lag by skew
  task automatic hold(logic [6:0] lit, int n, int skew);
    for (int h = 0; h < n; h++) begin
      @(negedge clk) bp = ~bp;
      repeat (skew) @(negedge clk);
      seg = lit ^ {7{bp}};
      repeat (HALF - 1 - skew) @(negedge clk);
    end
  endtask

  task automatic model_accept(logic [6:0] p);
    int k;
    k = ref_decode(p);
    m_pat = p;
    if (k <= 9) begin m_bcd = 4'(k); m_blank = 0; m_inv = 0; end
    else if (k == 10) begin m_blank = 1; m_inv = 0; end
    else begin m_blank = 0; m_inv = 1; end
  endtask

  task automatic check_outputs(string req);
    chk(req, "bcd", int'(bcd_o), int'(m_bcd));
    chk(req, "blank", int'(blank_o), int'(m_blank));
    chk(req, "invalid", int'(invalid_o), int'(m_inv));
  endtask

  task automatic apply(logic [6:0] p, int skew, string req);
    int exp_upd;
    upd_cnt = 0;
    hold(p, 6, skew);
    repeat (4) @(negedge clk);
    exp_upd = (p != m_pat) ? 1 : 0;
    model_accept(p);
    chk({req, " R8"}, "update count", upd_cnt, exp_upd);
    check_outputs(req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int sel, sk;
    logic [6:0] p;
    void'($urandom(32'd20250));
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9", "bcd", int'(bcd_o), 0);
    chk("R9", "blank", int'(blank_o), 1);
    chk("R9", "invalid", int'(invalid_o), 0);
    chk("R9", "update", int'(update_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R4 every digit, R1 across both backplane phases
    for (int d = 0; d <= 9; d++) apply(glyph(d), 2, "R4 R1");
    // R5 tail-less forms
    apply(glyph(10), 3, "R5");
    apply(glyph(11), 1, "R5");
    // R8 same digit via other glyph form of 9: no repeat on identical pattern
    apply(glyph(11), 0, "R8 same pattern");
    // R6 blank holds bcd
    apply(7'b0000000, 4, "R6");
    apply(glyph(3), 2, "R4");
    // R7 letters: A, P, H, L, E
    apply(7'b1110111, 2, "R7");
    apply(7'b1100111, 1, "R7");
    apply(7'b0110111, 3, "R7");
    apply(7'b0001110, 0, "R7");
    apply(7'b1001111, 4, "R7");
    apply(glyph(7), 2, "R4");

    // R3 short transient of 2 samples is ignored
    upd_cnt = 0;
    hold(glyph(2), 2, 1);
    hold(glyph(7), 4, 1);
    repeat (4) @(negedge clk);
    chk("R3", "update count", upd_cnt, 0);
    check_outputs("R3");

    // R2 settle beyond half-period: samples dropped
    settle = CNT_W'(HALF + 4);
    upd_cnt = 0;
    hold(glyph(5), 6, 1);
    repeat (4) @(negedge clk);
    chk("R2", "update count", upd_cnt, 0);
    check_outputs("R2");
    settle = CNT_W'(SETTLE);
    apply(glyph(5), 1, "R2");

    // constrained random
    for (int i = 0; i < 60; i++) begin
      sel = int'($urandom % 4);
      sk  = int'($urandom % 5);
      if (sel <= 1) p = glyph(int'($urandom % 12));
      else if (sel == 2) p = 7'b0000000;
      else p = 7'($urandom);
      apply(p, sk, "R4 R6 R7 random");
    end

    done = 1;
    finish_run();
  end
endmodule